// File: doc/BRIEF.md
# Serial Clock Rate Generator

This block turns the peripheral clock into the timing base of a two-wire serial bus master. Two programmable prescale stages are chained: a 2-bit stage (factor 1 to 4) and a 6-bit stage (factor 1 to 64). Together they produce one base step every M = (A+1)*(B+1) input clocks. A fixed sequencer then counts 22 base steps per bus period. It holds the nominal serial clock low for the first 11 steps and releases it for the last 11, so the bus frequency is Fin / (22*M). The fastest rate, Fin/22, occurs with both fields at zero.

The bus engine uses three outputs. The period strobe marks the first input clock of each period. The quarter tick marks four fixed points in the period, where the engine changes or samples data. The level output shows whether the serial clock should be pulled low or released. Software is expected to change the divider fields only while the bus is idle. The block still protects itself: it samples the fields only while disabled or on a period boundary, so no period is ever cut or stretched.

Top module: `scl_rate_gen`

## Requirements
- R1: With divider fields A and B, consecutive period strobes are exactly 22*(A+1)*(B+1) input clocks apart.
- R2: `scl_o` is 0 for the first 11*(A+1)*(B+1) clocks of each period, counting from the strobe cycle, and 1 for the remaining 11*(A+1)*(B+1) clocks.
- R3: `tick_o` pulses for one clock exactly four times per period, at offsets 0, 6*M, 11*M and 17*M clocks from the strobe cycle, where M=(A+1)*(B+1).
- R4: `period_start_o` is exactly one clock wide and falls in the first low cycle of the period, together with a tick.
- R5: A is 2 bits wide (factors 1..4) and B is 6 bits wide (factors 1..64). A=0,B=0 gives a 22-clock period and A=3,B=63 gives a 5632-clock period.
- R6: The divider inputs are sampled only while disabled and on the edge that ends a period. A change during a period leaves that period's length unchanged, and the next period uses the new values, including when the change lands in the last clock of a period.
- R7: One clock after `en_i` is sampled low, `scl_o` is 1 and `tick_o` and `period_start_o` are 0, and they stay so while disabled. The first clock after the edge that samples `en_i` high is a strobe cycle.
- R8: While `rst_ni` is low, `scl_o` is 1 and `tick_o` and `period_start_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears all counters and idles the clock high |
| div_a_i | input | 2 | First prescale field A (factor A+1) |
| div_b_i | input | 6 | Second prescale field B (factor B+1) |
| tick_o | output | 1 | Quarter-point pulse, one clock wide |
| scl_o | output | 1 | Nominal serial clock level (0 = drive low, 1 = release) |
| period_start_o | output | 1 | One-clock strobe on the first cycle of each period |

## Verification
The end of a period and the sampling of new divider values share one clock edge. This edge also carries the strobe and the first quarter tick of the next period. The bench provokes the collision by changing A and B in the very last clock of a running period, at a clock it computes from the old setting. It then judges the result at the ports: the period that is ending must still measure its old length, and the period that follows must show the new length, low-phase width and tick offsets. A second case changes the fields in the middle of a period, where the running period must be left untouched.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned BASE_STEPS = 22;
  localparam int unsigned HALF_STEPS = BASE_STEPS / 2;
  localparam int unsigned PH_W       = $clog2(BASE_STEPS);
  localparam int unsigned N_QTR      = 4;

  typedef logic [PH_W-1:0] phase_t;

  // quarter points: start and middle of each half
  function automatic logic is_quarter(phase_t p);
    logic hit;
    hit = 1'b0;
    for (int q = 0; q < N_QTR; q++) begin
      if (int'(p) == (q / 2) * HALF_STEPS + (q % 2) * ((HALF_STEPS + 1) / 2))
        hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         zero_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);
  assign wrap_o = step_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import scl_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   step_i,
  output phase_t phase_o,
  output logic   wrap_o,
  output logic   low_o
);
  phase_t phase_q;

  assign phase_o = phase_q;
  assign wrap_o  = step_i && (phase_q == phase_t'(BASE_STEPS - 1));
  assign low_o   = (phase_q < phase_t'(HALF_STEPS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (clr_i)   phase_q <= '0;
    else if (step_i)  phase_q <= wrap_o ? '0 : phase_q + 1'b1;
  end

  // R1
  phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < phase_t'(BASE_STEPS));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_div_pkg::*;
#(
  parameter int unsigned A_W = 2,
  parameter int unsigned B_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [A_W-1:0] div_a_i,
  input  logic [B_W-1:0] div_b_i,
  output logic           tick_o,
  output logic           scl_o,
  output logic           period_start_o
);
  logic           run_q;
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           a_zero, a_wrap, b_zero, b_wrap;
  logic           ph_wrap, ph_low, cfg_load, base_edge;
  phase_t         phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  // shadow copy: sampled only while idle or on a period boundary
  assign cfg_load = !run_q || ph_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (cfg_load) begin
      a_q <= div_a_i;
      b_q <= div_b_i;
    end
  end

  div_stage #(.W(A_W)) u_stage_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i),
    .step_i  (run_q),
    .limit_i (a_q),
    .zero_o  (a_zero),
    .wrap_o  (a_wrap)
  );

  div_stage #(.W(B_W)) u_stage_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i),
    .step_i  (a_wrap),
    .limit_i (b_q),
    .zero_o  (b_zero),
    .wrap_o  (b_wrap)
  );

  phase_seq u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i),
    .step_i  (b_wrap),
    .phase_o (phase),
    .wrap_o  (ph_wrap),
    .low_o   (ph_low)
  );

  assign base_edge      = run_q && a_zero && b_zero;
  assign scl_o          = run_q ? !ph_low : 1'b1;
  assign period_start_o = base_edge && (phase == '0);
  assign tick_o         = base_edge && is_quarter(phase);

  // R4
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |=> !period_start_o);

  // R4
  strobe_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> (tick_o && !scl_o));

  // R7
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !tick_o && !period_start_o));

  // R2
  scl_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> period_start_o);

  // R3
  scl_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(scl_o) && run_q) |-> tick_o);

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !ph_wrap) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] div_a_i = '0;
  logic [5:0] div_b_i = '0;
  logic       tick_o, scl_o, period_start_o;

  int total = 0;
  int bad   = 0;
  int m_cyc, m_low, m_tick;
  int m_off [4];

  // {A[1:0], B[5:0]}
  localparam logic [7:0] VEC [6] = '{8'h00, 8'h40, 8'h01, 8'hC2, 8'h87, 8'h4D};

  always #2.5 clk_i = ~clk_i;

  scl_rate_gen dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en_i),
    .div_a_i        (div_a_i),
    .div_b_i        (div_b_i),
    .tick_o         (tick_o),
    .scl_o          (scl_o),
    .period_start_o (period_start_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one period from a strobe cycle up to the next; optional input change at offset chg_at
  task automatic measure(input int chg_at, input logic [1:0] na, input logic [5:0] nb);
    int guard;
    guard = 0;
    while (!period_start_o && guard < 20000) begin
      @(negedge clk_i);
      guard++;
    end
    m_cyc = 0; m_low = 0; m_tick = 0;
    for (int q = 0; q < 4; q++) m_off[q] = -1;
    do begin
      if (!scl_o) m_low++;
      if (tick_o) begin
        if (m_tick < 4) m_off[m_tick] = m_cyc;
        m_tick++;
      end
      if (m_cyc == chg_at) begin
        div_a_i = na;
        div_b_i = nb;
      end
      m_cyc++;
      @(negedge clk_i);
    end while (!period_start_o && m_cyc < 20000);
  endtask

  task automatic check_period(input string req, input int m);
    chk({req, " period"}, m_cyc, 22 * m);
    chk("R2 low width", m_low, 11 * m);
    chk("R3 tick count", m_tick, 4);
    chk("R3 tick q0", m_off[0], 0);
    chk("R3 tick q1", m_off[1], 6 * m);
    chk("R3 tick q2", m_off[2], 11 * m);
    chk("R3 tick q3", m_off[3], 17 * m);
  endtask

  task automatic start(input logic [1:0] a, input logic [5:0] b);
    @(negedge clk_i);
    en_i = 1'b0;
    div_a_i = a;
    div_b_i = b;
    @(negedge clk_i);
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R7 first strobe", int'(period_start_o), 1);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk_i);
    chk("R8 scl", int'(scl_o), 1);
    chk("R8 tick", int'(tick_o), 0);
    chk("R8 strobe", int'(period_start_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R7 idle scl", int'(scl_o), 1);

    // table walk: R1, R2, R3 across settings (first entry is the R5 minimum)
    for (int i = 0; i < 6; i++) begin
      logic [1:0] a;
      logic [5:0] b;
      int m;
      a = VEC[i][7:6];
      b = VEC[i][5:0];
      m = (int'(a) + 1) * (int'(b) + 1);
      start(a, b);
      measure(-1, a, b);
      check_period("R1", m);
      measure(-1, a, b);
      chk("R1 second period", m_cyc, 22 * m);
    end

    // R5 maximum setting
    start(2'd3, 6'd63);
    measure(-1, 2'd3, 6'd63);
    check_period("R5 max", 256);

    // R6 mid-period change: current period keeps old length
    start(2'd1, 6'd1);
    measure(10, 2'd0, 6'd2);
    chk("R6 mid old period", m_cyc, 88);
    measure(-1, 2'd0, 6'd2);
    check_period("R6 mid new", 3);

    // R6 change in the last clock of a period
    start(2'd0, 6'd3);
    measure(87, 2'd2, 6'd0);
    chk("R6 last-clock old period", m_cyc, 88);
    measure(-1, 2'd2, 6'd0);
    check_period("R6 last-clock new", 3);

    // R7 disable mid-run then re-enable
    start(2'd0, 6'd1);
    repeat (15) @(negedge clk_i);
    chk("R7 running low", int'(scl_o), 0);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R7 off scl", int'(scl_o), 1);
    chk("R7 off tick", int'(tick_o), 0);
    chk("R7 off strobe", int'(period_start_o), 0);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 40; k++) begin
        if (!scl_o || tick_o || period_start_o) seen++;
        @(negedge clk_i);
      end
      chk("R7 stays idle", seen, 0);
    end
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R7 re-enable strobe", int'(period_start_o), 1);
    measure(-1, 2'd0, 6'd1);
    check_period("R7 restart", 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule